// File: doc/BRIEF.md
# Dual-Set PIO Strobe Timing Generator

This block times register and programmed-I/O accesses on a parallel disk channel that carries two devices. Each access runs through four phases: address setup, strobe active, write hold and recovery. Every phase length is counted in system clocks and is taken from one of two programmable timing words. The regular word is meant to suit the slower device. The fast word is used by the device that the fast-device selector names.

The device being addressed is tracked from bit 4 of the last data value written to the device/head register. During the strobe phase, a low ready input stretches the strobe beyond its programmed length. The stretch ends when ready returns or when a programmable timeout runs out. A timeout leaves a sticky flag set.

The client side is a simple request/acknowledge. A request is taken only while `req_ready` is high, and `ack` pulses once for each access.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `req_ready` is 1 and `strobe_rd`, `strobe_wr`, `data_oe`, `ack`, `tmo_flag` and `dev_sel` are 0. Both timing words reset to setup 6, active 19, recovery 15, hold 2, so a read then shows 8 setup, 20 strobe and 16 recovery cycles.
- R2: A timing word holds setup in bits [30:27], strobe active in [25:20], recovery in [18:13] and write hold in [11:9]. Setup lasts the field value plus 2 clocks, the strobe lasts active plus 1, and recovery lasts recovery plus 1. All values from 0 up to the field maximum are honoured.
- R3: Hold applies only to writes. A write spends exactly the hold field's number of clocks between strobe release and recovery, and a hold of 0 skips the phase. `data_oe` is high from setup through hold on writes and is never high on reads.
- R4: `ack` is high for exactly one clock, the first clock of recovery. `req_ready` returns high only after recovery ends, and a request is accepted only while `req_ready` is high.
- R5: An accepted write with `req_devhead`=1 sets `dev_sel` to `req_wdata[4]`, and that same access already uses the device it names. Reads, and writes with `req_devhead`=0, leave `dev_sel` unchanged.
- R6: An access whose device equals `fast_dev` uses the fast timing word. Any other access uses the regular word.
- R7: When the programmed strobe count has elapsed, the strobe stays asserted for as long as `rdy` is sampled low at a clock edge. It is released at the first edge where `rdy` is high.
- R8: The strobe is stretched by at most T = 8*`rdyt`+1 clocks beyond its programmed length. When T is reached, the strobe is released, the access completes normally, and `tmo_flag` becomes 1.
- R9: `tmo_flag` stays 1 until `tmo_clr` is pulsed. A timeout in the same clock as a clear wins.
- R10: The timing word is captured when a request is accepted. Loading either word during an access changes only later accesses.
- R11: `strobe_rd` and `strobe_wr` are never high together, and the one that rises matches `req_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_ld_regular | input | 1 | Load `tim_ld_word` into the regular timing word |
| tim_ld_fast | input | 1 | Load `tim_ld_word` into the fast timing word |
| tim_ld_word | input | 32 | Timing word value (field layout as in R2) |
| fast_dev | input | 1 | Device number that uses the fast word |
| rdyt | input | RDYT_W | Ready timeout setting, T = 8*rdyt+1 |
| tmo_clr | input | 1 | Clear the sticky timeout flag |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_devhead | input | 1 | Access targets the device/head register |
| req_wdata | input | 8 | Write data (bit 4 is the device select) |
| rdy | input | 1 | Device ready; low stretches the strobe |
| req_ready | output | 1 | Idle, a request may be accepted |
| strobe_rd | output | 1 | Read strobe |
| strobe_wr | output | 1 | Write strobe |
| data_oe | output | 1 | Write data drive enable |
| ack | output | 1 | One-clock pulse at the start of recovery |
| dev_sel | output | 1 | Device named by the last device/head write |
| tmo_flag | output | 1 | Sticky ready-timeout flag |

## Verification
The first setup clock follows one clock after the accept edge. The strobe comes S+2 clocks after that, `ack` comes H clocks after the strobe falls, and `req_ready` rises R+1 clocks after `ack` first appears. The strobe lasts A+1 clocks, or up to A+1+T clocks when `rdy` is low.

A monitor samples on the falling edge and counts each of these intervals directly. It compares the counts against items the driver queued at request time, computed from the timing word values the bench itself loaded.

Tests that drive `rdy` raise it at a falling edge a known number of clocks after the strobe is first seen. The expected strobe length therefore follows from which rising edge first sees `rdy` high.

// File: rtl/pio_tim_pkg.sv
// Shared types and helpers for the PIO strobe timer.
// Assumes the fixed timing-word field layout used by software.
package pio_tim_pkg;

    // One decoded timing set.
    typedef struct packed {
        logic [3:0] setup;
        logic [5:0] active;
        logic [5:0] recov;
        logic [2:0] hold;
    } tim_set_t;

    // Access phases.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } phase_t;

    // Phase counter wide enough for the longest phase (64 clocks).
    localparam int CNT_W = 7;

    // Timing word reset value: setup 6, active 19, recovery 15, hold 2.
    localparam logic [31:0] TIM_RESET_WORD =
        (32'd6 << 27) | (32'd19 << 20) | (32'd15 << 13) | (32'd2 << 9);

    // Extract the fields of a timing word.
    function automatic tim_set_t tim_unpack(input logic [31:0] w);
        tim_set_t t;
        t.setup  = w[30:27];
        t.active = w[25:20];
        t.recov  = w[18:13];
        t.hold   = w[11:9];
        return t;
    endfunction

endpackage

// File: rtl/pio_timing_bank.sv
// Holds the regular and fast timing words and tracks the addressed device.
// Chooses the set for an access being accepted this cycle; a device/head
// write applies its own device select to itself.
module pio_timing_bank
    import pio_tim_pkg::*;
#(
    parameter int DEV_BIT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_regular,
    input  logic        ld_fast,
    input  logic [31:0] ld_word,
    input  logic        fast_dev,
    input  logic        acc_go,
    input  logic        acc_write,
    input  logic        acc_devhead,
    input  logic [7:0]  acc_wdata,
    output tim_set_t    eff_set,
    output logic        dev_now
);
    logic [31:0] regular_q;
    logic [31:0] fast_q;
    logic        dev_q;
    logic        dh_wr;
    logic        eff_dev;
    logic        unused_bits;

    assign dh_wr   = acc_go && acc_write && acc_devhead;
    assign eff_dev = dh_wr ? acc_wdata[DEV_BIT] : dev_q;

    // Timing word storage with independent load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regular_q <= TIM_RESET_WORD;
            fast_q    <= TIM_RESET_WORD;
        end else begin
            if (ld_regular) regular_q <= ld_word;
            if (ld_fast)    fast_q    <= ld_word;
        end
    end

    // Device tracking from accepted device/head writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     dev_q <= 1'b0;
        else if (dh_wr) dev_q <= acc_wdata[DEV_BIT];
    end

    // Set selection for the access being accepted.
    always_comb begin
        eff_set = tim_unpack((eff_dev == fast_dev) ? fast_q : regular_q);
    end

    assign dev_now     = dev_q;
    assign unused_bits = ^{acc_wdata, regular_q, fast_q};
endmodule

// File: rtl/pio_ready_watch.sv
// Counts strobe-stretch clocks while ready is low and flags a timeout.
// Assumes 'armed' is high only for the strobe phase past its programmed count.
module pio_ready_watch #(
    parameter int RDYT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RDYT_W-1:0] rdyt,
    input  logic              armed,
    input  logic              tmo_clr,
    output logic              expire,
    output logic              tmo_sticky
);
    localparam int TMO_W = RDYT_W + 3;

    logic [TMO_W-1:0] limit;
    logic [TMO_W-1:0] wcnt;

    assign limit  = {rdyt, 3'b000} + TMO_W'(1);
    assign expire = armed && (wcnt == limit);

    // Stretch counter, cleared whenever the wait is not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) wcnt <= '0;
        else                  wcnt <= wcnt + TMO_W'(1);
    end

    // Sticky timeout flag; a new timeout beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_sticky <= 1'b0;
        else if (expire)  tmo_sticky <= 1'b1;
        else if (tmo_clr) tmo_sticky <= 1'b0;
    end
endmodule

// File: rtl/pio_phase_seq.sv
// Phase sequencer: setup, strobe, hold (writes only) and recovery.
// Captures the timing set at acceptance; ready and expire steer the strobe end.
module pio_phase_seq
    import pio_tim_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  logic     req_write,
    input  tim_set_t eff_set,
    input  logic     rdy,
    input  logic     expire,
    output logic     acc_go,
    output logic     armed,
    output logic     req_ready,
    output logic     strobe_rd,
    output logic     strobe_wr,
    output logic     data_oe,
    output logic     ack
);
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    tim_set_t         cur;
    logic             wr_q;
    logic             ack_q;
    logic             cnt_zero;
    logic             strobe_end;

    assign cnt_zero   = (cnt == '0);
    assign acc_go     = (ph == PH_IDLE) && req;
    assign armed      = (ph == PH_ACTIVE) && cnt_zero && !rdy;
    assign strobe_end = (ph == PH_ACTIVE) && cnt_zero && (rdy || expire);

    // Phase state, phase counter and captured access attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
            wr_q  <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            unique case (ph)
                PH_IDLE: if (req) begin
                    ph   <= PH_SETUP;
                    cnt  <= CNT_W'(eff_set.setup) + CNT_W'(1);
                    cur  <= eff_set;
                    wr_q <= req_write;
                end
                PH_SETUP: if (cnt_zero) begin
                    ph  <= PH_ACTIVE;
                    cnt <= CNT_W'(cur.active);
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                PH_ACTIVE: if (!cnt_zero) begin
                    cnt <= cnt - CNT_W'(1);
                end else if (strobe_end) begin
                    if (wr_q && (cur.hold != 3'd0)) begin
                        ph  <= PH_HOLD;
                        cnt <= CNT_W'(cur.hold) - CNT_W'(1);
                    end else begin
                        ph    <= PH_RECOV;
                        cnt   <= CNT_W'(cur.recov);
                        ack_q <= 1'b1;
                    end
                end
                PH_HOLD: if (cnt_zero) begin
                    ph    <= PH_RECOV;
                    cnt   <= CNT_W'(cur.recov);
                    ack_q <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                PH_RECOV: if (cnt_zero) ph <= PH_IDLE;
                          else          cnt <= cnt - CNT_W'(1);
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (ph == PH_IDLE);
    assign strobe_rd = (ph == PH_ACTIVE) && !wr_q;
    assign strobe_wr = (ph == PH_ACTIVE) && wr_q;
    assign data_oe   = wr_q && (ph == PH_SETUP || ph == PH_ACTIVE || ph == PH_HOLD);
    assign ack       = ack_q;
endmodule

// File: rtl/pio_strobe_timer.sv
// Top: dual-set PIO strobe timing generator for a two-device channel.
// Assumes inputs are synchronous to clk; rdy is sampled at each edge.
module pio_strobe_timer
    import pio_tim_pkg::*;
#(
    parameter int RDYT_W  = 4,
    parameter int DEV_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tim_ld_regular,
    input  logic              tim_ld_fast,
    input  logic [31:0]       tim_ld_word,
    input  logic              fast_dev,
    input  logic [RDYT_W-1:0] rdyt,
    input  logic              tmo_clr,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_devhead,
    input  logic [7:0]        req_wdata,
    input  logic              rdy,
    output logic              req_ready,
    output logic              strobe_rd,
    output logic              strobe_wr,
    output logic              data_oe,
    output logic              ack,
    output logic              dev_sel,
    output logic              tmo_flag
);
    tim_set_t eff_set;
    logic     acc_go;
    logic     armed;
    logic     expire;

    pio_timing_bank #(.DEV_BIT(DEV_BIT)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_regular  (tim_ld_regular),
        .ld_fast     (tim_ld_fast),
        .ld_word     (tim_ld_word),
        .fast_dev    (fast_dev),
        .acc_go      (acc_go),
        .acc_write   (req_write),
        .acc_devhead (req_devhead),
        .acc_wdata   (req_wdata),
        .eff_set     (eff_set),
        .dev_now     (dev_sel)
    );

    pio_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_write (req_write),
        .eff_set   (eff_set),
        .rdy       (rdy),
        .expire    (expire),
        .acc_go    (acc_go),
        .armed     (armed),
        .req_ready (req_ready),
        .strobe_rd (strobe_rd),
        .strobe_wr (strobe_wr),
        .data_oe   (data_oe),
        .ack       (ack)
    );

    pio_ready_watch #(.RDYT_W(RDYT_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdyt       (rdyt),
        .armed      (armed),
        .tmo_clr    (tmo_clr),
        .expire     (expire),
        .tmo_sticky (tmo_flag)
    );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
// Property checker for pio_strobe_timer, attached by bind to every instance.
// Observes the top-level ports only.
module pio_strobe_timer_chk #(
    parameter int RDYT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tim_ld_regular,
    input logic              tim_ld_fast,
    input logic [31:0]       tim_ld_word,
    input logic              fast_dev,
    input logic [RDYT_W-1:0] rdyt,
    input logic              tmo_clr,
    input logic              req,
    input logic              req_write,
    input logic              req_devhead,
    input logic [7:0]        req_wdata,
    input logic              rdy,
    input logic              req_ready,
    input logic              strobe_rd,
    input logic              strobe_wr,
    input logic              data_oe,
    input logic              ack,
    input logic              dev_sel,
    input logic              tmo_flag
);
    logic unused_chk;
    assign unused_chk = ^{tim_ld_regular, tim_ld_fast, tim_ld_word, fast_dev, rdyt, req_wdata, rdy};

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_rd && strobe_wr));

    assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rd |-> !data_oe);

    assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_ready) |=> !req_ready);

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_in_recovery_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!req_ready && !strobe_rd && !strobe_wr && !data_oe));

    assert_dev_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_sel) |-> $past(req && req_ready && req_write && req_devhead));

    assert_tmo_from_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(strobe_rd || strobe_wr));

    assert_tmo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

    assert_strobe_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_ready) |=> ($past(req_write) ? !strobe_rd : !strobe_wr) && !ack);
endmodule

bind pio_strobe_timer pio_strobe_timer_chk #(.RDYT_W(RDYT_W)) u_chk (.*);

// File: tb/tb_pio_strobe_timer.sv
// Scoreboard bench: the driver queues expected phase lengths, the monitor
// measures them at the falling edge and compares.
module tb_pio_strobe_timer;
    localparam int RDYT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tim_ld_regular, tim_ld_fast;
    logic [31:0]       tim_ld_word;
    logic              fast_dev;
    logic [RDYT_W-1:0] rdyt;
    logic              tmo_clr, req, req_write, req_devhead, rdy;
    logic [7:0]        req_wdata;
    logic              req_ready, strobe_rd, strobe_wr, data_oe, ack, dev_sel, tmo_flag;

    typedef struct {
        int    s, a, h, r;
        bit    wr;
        string tag;
    } exp_t;

    exp_t        sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [31:0] m_reg, m_fast;
    logic        m_dev;

    always #2.5 clk = ~clk;

    pio_strobe_timer #(.RDYT_W(RDYT_W)) dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] word(input int s, a, r, h);
        return (32'(s) << 27) | (32'(a) << 20) | (32'(r) << 13) | (32'(h) << 9);
    endfunction

    task automatic load(input bit fast, input logic [31:0] w);
        @(negedge clk);
        tim_ld_word = w;
        if (fast) begin tim_ld_fast = 1; m_fast = w; end
        else      begin tim_ld_regular = 1; m_reg = w; end
        @(negedge clk);
        tim_ld_fast = 0;
        tim_ld_regular = 0;
    endtask

    // rmode: -1 ready high, -2 ready held low, K>=0 raise K clocks after strobe seen.
    // mid_en loads mid_w into the regular word while the access is in flight.
    task automatic access(input bit wr, input bit dh, input logic [7:0] wd,
                          input int rmode, input bit mid_en, input logic [31:0] mid_w,
                          input string tag);
        exp_t        e;
        logic [31:0] w;
        int          s, a, r, h, t, base;
        while (!req_ready) @(negedge clk);
        if (wr && dh) m_dev = wd[4];
        w = (m_dev == fast_dev) ? m_fast : m_reg;
        s = int'(w[30:27]); a = int'(w[25:20]); r = int'(w[18:13]); h = int'(w[11:9]);
        t = 8 * int'(rdyt) + 1;
        base = a + 1;
        e.s = s + 2; e.h = wr ? h : 0; e.r = r + 1; e.wr = wr; e.tag = tag;
        if (rmode == -1)      e.a = base;
        else if (rmode == -2) e.a = base + t;
        else                  e.a = ((rmode + 1 > base) ? rmode + 1 : base) < base + t ?
                                    ((rmode + 1 > base) ? rmode + 1 : base) : base + t;
        sb.push_back(e);
        if (rmode != -1) rdy = 0;
        req = 1; req_write = wr; req_devhead = dh; req_wdata = wd;
        @(negedge clk);
        req = 0;
        if (mid_en) begin
            @(negedge clk);
            tim_ld_word = mid_w; tim_ld_regular = 1;
            @(negedge clk);
            tim_ld_regular = 0; m_reg = mid_w;
        end
        if (rmode >= 0) begin
            while (!(strobe_rd || strobe_wr)) @(negedge clk);
            repeat (rmode) @(negedge clk);
            rdy = 1;
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rdy = 1;
    endtask

    // Monitor: measure the phases of each access and compare to the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !req_ready) begin
                exp_t e;
                int   s, a, h, r;
                bit   was_wr, oe_ok;
                s = 0; a = 0; h = 0; r = 0; oe_ok = 1;
                e = sb.size() > 0 ? sb.pop_front() : '{0, 0, 0, 0, 0, "NOEXP"};
                while (!(strobe_rd || strobe_wr)) begin
                    if (data_oe !== e.wr) oe_ok = 0;
                    s++; @(negedge clk);
                end
                was_wr = strobe_wr;
                while (strobe_rd || strobe_wr) begin
                    if (data_oe !== e.wr) oe_ok = 0;
                    a++; @(negedge clk);
                end
                while (!ack) begin
                    if (data_oe !== 1'b1) oe_ok = 0;
                    h++; @(negedge clk);
                end
                while (!req_ready) begin
                    if (data_oe !== 1'b0) oe_ok = 0;
                    r++; @(negedge clk);
                end
                chk(s == e.s, {e.tag, " setup R2"}, s, e.s);
                chk(a == e.a, {e.tag, " active R2 R7 R8"}, a, e.a);
                chk(h == e.h, {e.tag, " hold R3"}, h, e.h);
                chk(r == e.r, {e.tag, " recovery R4"}, r, e.r);
                chk(was_wr == e.wr, {e.tag, " strobe kind R11"}, int'(was_wr), int'(e.wr));
                chk(oe_ok, {e.tag, " data_oe R3"}, int'(oe_ok), 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tim_ld_regular = 0; tim_ld_fast = 0; tim_ld_word = 0;
        fast_dev = 1; rdyt = 0; tmo_clr = 0; req = 0; req_write = 0;
        req_devhead = 0; req_wdata = 0; rdy = 1;
        m_reg = word(6, 19, 15, 2); m_fast = m_reg; m_dev = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk({strobe_rd, strobe_wr, data_oe, ack} === 4'b0, "R1 outputs idle",
            int'({strobe_rd, strobe_wr, data_oe, ack}), 0);
        chk(tmo_flag === 1'b0, "R1 tmo_flag", int'(tmo_flag), 0);
        chk(dev_sel === 1'b0, "R1 dev_sel", int'(dev_sel), 0);

        access(0, 0, 8'h00, -1, 0, 0, "R1 reset read");
        access(1, 0, 8'h00, -1, 0, 0, "R1 reset write");

        load(0, word(3, 5, 4, 3));
        load(1, word(0, 1, 0, 1));
        access(1, 1, 8'h10, -1, 0, 0, "R5 R6 devhead dev1 fast");
        chk(dev_sel === 1'b1, "R5 dev_sel after devhead write", int'(dev_sel), 1);
        access(0, 0, 8'h00, -1, 0, 0, "R6 read fast");
        access(1, 0, 8'h00, -1, 0, 0, "R5 plain write keeps dev");
        chk(dev_sel === 1'b1, "R5 dev_sel kept on plain write", int'(dev_sel), 1);
        access(0, 1, 8'h00, -1, 0, 0, "R5 devhead read keeps dev");
        chk(dev_sel === 1'b1, "R5 dev_sel kept on read", int'(dev_sel), 1);
        access(1, 1, 8'hE0, -1, 0, 0, "R5 R6 devhead dev0 regular");
        chk(dev_sel === 1'b0, "R5 dev_sel back to 0", int'(dev_sel), 0);
        fast_dev = 0;
        access(0, 0, 8'h00, -1, 0, 0, "R6 fast_dev 0");
        fast_dev = 1;

        load(0, word(15, 63, 63, 7));
        access(1, 0, 8'h00, -1, 0, 0, "R2 field maxima");
        load(0, word(1, 0, 2, 0));
        access(1, 0, 8'h00, -1, 0, 0, "R3 zero hold");

        load(0, word(1, 2, 1, 0));
        rdyt = 2;
        access(0, 0, 8'h00, 8, 0, 0, "R7 ready late");
        access(0, 0, 8'h00, 1, 0, 0, "R7 ready early");
        chk(tmo_flag === 1'b0, "R7 no timeout", int'(tmo_flag), 0);
        rdyt = 0;
        access(0, 0, 8'h00, -2, 0, 0, "R8 timeout rdyt0");
        chk(tmo_flag === 1'b1, "R8 flag set", int'(tmo_flag), 1);
        access(0, 0, 8'h00, -1, 0, 0, "R9 normal after timeout");
        chk(tmo_flag === 1'b1, "R9 flag sticky", int'(tmo_flag), 1);
        tmo_clr = 1; @(negedge clk); tmo_clr = 0;
        chk(tmo_flag === 1'b0, "R9 flag cleared", int'(tmo_flag), 0);
        rdyt = 1;
        access(1, 0, 8'h00, -2, 0, 0, "R8 timeout rdyt1 write");
        chk(tmo_flag === 1'b1, "R8 flag set again", int'(tmo_flag), 1);
        tmo_clr = 1; @(negedge clk); tmo_clr = 0;

        access(0, 0, 8'h00, -1, 1, word(4, 9, 3, 2), "R10 load during access");
        access(1, 0, 8'h00, -1, 0, 0, "R10 new word next access");
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule